// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block chooses where each atomic memory operation runs. It can run near, in the L1 cache of the core that asks for it. It can also run far, at a shared outer level of the hierarchy. The choice is made per cache block. The block keeps a small direct-mapped table. Each entry holds a tag, a valid bit, the ID of the core that last issued an atomic to that block, and a saturating counter. The counter holds the length of the current run of atomics from that one core.

A request carries a block address, a core ID and a threshold. The decision is registered and appears one cycle after the request. The table entry is written at the same clock edge. A block that has been claimed by one core for more than `thresh_i` atomics in a row is predicted near. A block with a new owner, a new tag, or a short run is predicted far. Coherence, the atomic arithmetic and the memory access are handled elsewhere.

Top module: `atomic_place_pred`

## Requirements
- R1: `dec_valid_o` is 1 exactly one cycle after a cycle with `req_valid_i` = 1, and 0 one cycle after a cycle with `req_valid_i` = 0. `dec_near_o` is 0 whenever `dec_valid_o` is 0.
- R2: A request whose entry is invalid or holds a different tag is a miss. A miss gives a far decision (`dec_near_o` = 0) and allocates the entry with the requester's core ID and a count of 1.
- R3: A hit from the recorded core increments the count. The decision is near (`dec_near_o` = 1) when the new count is strictly greater than `thresh_i`, where `thresh_i` is sampled in the same cycle as the request. With `thresh_i` = 2, a core's 3rd consecutive atomic to a block is the first one predicted near.
- R4: A hit from a core other than the recorded one gives a far decision. It also overwrites the recorded core with the new core ID and sets the count to 1.
- R5: The count saturates at 2^CNT_W-1 (7 for the default CNT_W = 3) and never wraps. With `thresh_i` = 6, every access after the 6th in a run is near. With `thresh_i` = 7, no access is near.
- R6: The table index is the low IDX_W bits of `req_addr_i` and the tag is the remaining upper bits. Two addresses that share an index evict each other.
- R7: Back-to-back requests, one per cycle, to the same entry each see the state written by the previous request.
- R8: Asserting `rst_ni` low clears every valid bit and both decision outputs. After reset, the first request to any block is far.
- R9: Cycles with `req_valid_i` = 0 leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Atomic request present this cycle |
| req_addr_i | input | ADDR_W | Cache-block address of the atomic |
| req_core_i | input | CORE_W | ID of the requesting core |
| thresh_i | input | CNT_W | Run length that must be exceeded to predict near |
| dec_valid_o | output | 1 | Decision present (one cycle after request) |
| dec_near_o | output | 1 | 1 = run in requester L1, 0 = send to outer level |

## Verification
Every decision is due exactly one clock edge after its request. The bench drives each request at a falling edge, so the rising edge in between captures it. It then reads `dec_valid_o` and `dec_near_o` at the next falling edge. Requests that follow each other are issued on consecutive falling edges, so each decision is checked in the same cycle that the next request is presented. This checks R7 without any gap. Reset is checked asynchronously, shortly after `rst_ni` falls.

// File: rtl/apred_pkg.sv
package apred_pkg;
  typedef enum logic {
    PLACE_FAR  = 1'b0,
    PLACE_NEAR = 1'b1
  } place_e;
endpackage

// File: rtl/apred_table.sv
module apred_table #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int CORE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [CORE_W-1:0] wr_core_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [CORE_W-1:0] rd_core_o,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [CORE_W-1:0]  core_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[e] <= 1'b0;
      else if (sel) vld_q[e] <= 1'b1;
    end

    // payload needs no reset: guarded by vld_q
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[e]  <= wr_tag_i;
        core_q[e] <= wr_core_i;
        cnt_q[e]  <= wr_cnt_i;
      end
    end
  end

  assign rd_vld_o  = vld_q[idx_i];
  assign rd_tag_o  = tag_q[idx_i];
  assign rd_core_o = core_q[idx_i];
  assign rd_cnt_o  = cnt_q[idx_i];
endmodule

// File: rtl/apred_train.sv
module apred_train
  import apred_pkg::*;
#(
  parameter int TAG_W  = 12,
  parameter int CORE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic              rd_vld_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [CORE_W-1:0] rd_core_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  nxt_cnt_o,
  output place_e            place_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic same_core;
  logic [CNT_W-1:0] inc_cnt;

  assign hit_o     = rd_vld_i && (rd_tag_i == req_tag_i);
  assign same_core = hit_o && (rd_core_i == req_core_i);
  assign inc_cnt   = (rd_cnt_i == CNT_MAX) ? CNT_MAX : rd_cnt_i + CNT_W'(1);

  always_comb begin
    if (same_core) begin
      nxt_cnt_o = inc_cnt;
      place_o   = (inc_cnt > thresh_i) ? PLACE_NEAR : PLACE_FAR;
    end else begin
      // miss or owner change: restart the run
      nxt_cnt_o = CNT_W'(1);
      place_o   = PLACE_FAR;
    end
  end
endmodule

// File: rtl/atomic_place_pred.sv
module atomic_place_pred
  import apred_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int CORE_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic              dec_valid_o,
  output logic              dec_near_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              rd_vld;
  logic [TAG_W-1:0]  rd_tag;
  logic [CORE_W-1:0] rd_core;
  logic [CNT_W-1:0]  rd_cnt;
  logic              hit;
  logic [CNT_W-1:0]  nxt_cnt;
  place_e            place;

  assign idx = req_addr_i[IDX_W-1:0];
  assign tag = req_addr_i[ADDR_W-1:IDX_W];

  apred_table #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .CORE_W(CORE_W), .CNT_W(CNT_W)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (idx),
    .wr_en_i  (req_valid_i),
    .wr_tag_i (tag),
    .wr_core_i(req_core_i),
    .wr_cnt_i (nxt_cnt),
    .rd_vld_o (rd_vld),
    .rd_tag_o (rd_tag),
    .rd_core_o(rd_core),
    .rd_cnt_o (rd_cnt)
  );

  apred_train #(
    .TAG_W(TAG_W), .CORE_W(CORE_W), .CNT_W(CNT_W)
  ) u_train (
    .req_tag_i (tag),
    .req_core_i(req_core_i),
    .thresh_i  (thresh_i),
    .rd_vld_i  (rd_vld),
    .rd_tag_i  (rd_tag),
    .rd_core_i (rd_core),
    .rd_cnt_i  (rd_cnt),
    .hit_o     (hit),
    .nxt_cnt_o (nxt_cnt),
    .place_o   (place)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_near_o  <= 1'b0;
    end else begin
      dec_valid_o <= req_valid_i;
      dec_near_o  <= req_valid_i && (place == PLACE_NEAR);
    end
  end
endmodule

// File: rtl/apred_chk.sv
module apred_chk #(
  parameter int ADDR_W = 16,
  parameter int CORE_W = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [CORE_W-1:0] req_core_i,
  input logic [CNT_W-1:0]  thresh_i,
  input logic              dec_valid_o,
  input logic              dec_near_o,
  input logic              hit,
  input logic [CNT_W-1:0]  nxt_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              last_vld;
  logic [ADDR_W-1:0] last_addr;
  logic [CORE_W-1:0] last_core;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld  <= 1'b0;
      last_addr <= '0;
      last_core <= '0;
    end else if (req_valid_i) begin
      last_vld  <= 1'b1;
      last_addr <= req_addr_i;
      last_core <= req_core_i;
    end
  end

  AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o); // R1
  AST_NO_DEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o); // R1
  AST_NEAR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_near_o |-> dec_valid_o); // R1
  AST_MISS_FAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> !dec_near_o); // R2
  AST_OWNER_CHANGE_FAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && last_vld && req_addr_i == last_addr && req_core_i != last_core)
      |=> !dec_near_o); // R4
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (nxt_cnt != '0)); // R5
  AST_MAX_THRESH_FAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && thresh_i == CNT_MAX) |=> !dec_near_o); // R5
endmodule

bind atomic_place_pred apred_chk #(
  .ADDR_W(ADDR_W), .CORE_W(CORE_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_core_i (req_core_i),
  .thresh_i   (thresh_i),
  .dec_valid_o(dec_valid_o),
  .dec_near_o (dec_near_o),
  .hit        (hit),
  .nxt_cnt    (nxt_cnt)
);

// File: tb/atomic_place_pred_test.sv
module atomic_place_pred_test;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int CORE_W = 2;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CORE_W-1:0] req_core = '0;
  logic [CNT_W-1:0]  thresh = '0;
  logic              dec_valid;
  logic              dec_near;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  atomic_place_pred #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_W(CORE_W), .CNT_W(CNT_W)
  ) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid),
    .req_addr_i (req_addr),
    .req_core_i (req_core),
    .thresh_i   (thresh),
    .dec_valid_o(dec_valid),
    .dec_near_o (dec_near)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive a request at negedge; decision sampled at the following negedge
  task automatic send(input logic [ADDR_W-1:0] a, input logic [CORE_W-1:0] c,
                      input logic exp_near, input string req);
    req_valid = 1'b1; req_addr = a; req_core = c;
    @(negedge clk);
    chk(dec_valid == 1'b1, "R1 valid", int'(dec_valid), 1);
    chk(dec_near == exp_near, req, int'(dec_near), int'(exp_near));
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dec_valid == 1'b0 && dec_near == 1'b0, "R1 idle", int'(dec_valid), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(dec_valid == 1'b0, "R8 reset valid", int'(dec_valid), 0);
    chk(dec_near == 1'b0, "R8 reset near", int'(dec_near), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_run();  // R3 R7
    thresh = 3'd2;
    send(16'h0003, 2'd1, 1'b0, "R2 first access far");
    send(16'h0003, 2'd1, 1'b0, "R3 count2 far");
    send(16'h0003, 2'd1, 1'b1, "R3 count3 near");
    send(16'h0003, 2'd1, 1'b1, "R7 back-to-back near");
    idle(1);
  endtask

  task automatic t_owner();  // R4
    thresh = 3'd2;
    send(16'h0003, 2'd2, 1'b0, "R4 new owner far");
    send(16'h0003, 2'd2, 1'b0, "R4 restart count2 far");
    send(16'h0003, 2'd2, 1'b1, "R4 new owner near at 3");
    send(16'h0003, 2'd1, 1'b0, "R4 old owner far");
    send(16'h0003, 2'd2, 1'b0, "R4 ping-pong far");
    idle(1);
  endtask

  task automatic t_alias();  // R6
    thresh = 3'd2;
    for (int i = 0; i < 3; i++) send(16'h0005, 2'd3, i == 2, "R6 train A");
    send(16'h0105, 2'd3, 1'b0, "R6 alias miss far");
    send(16'h0005, 2'd3, 1'b0, "R6 evicted far");
    send(16'h0006, 2'd3, 1'b0, "R6 other index far");
    send(16'h0005, 2'd3, 1'b0, "R6 index untouched count2");
    send(16'h0005, 2'd3, 1'b1, "R6 index untouched near");
    idle(1);
  endtask

  task automatic t_sat();  // R5
    thresh = 3'd6;
    for (int i = 1; i <= 16; i++)
      send(16'h0209, 2'd0, i > 6, "R5 saturate thresh6");
    thresh = 3'd7;
    for (int i = 0; i < 3; i++) send(16'h0209, 2'd0, 1'b0, "R5 thresh7 never near");
    thresh = 3'd6;
    send(16'h0209, 2'd0, 1'b1, "R5 held at max");
    thresh = 3'd0;
    send(16'h020A, 2'd0, 1'b0, "R2 miss far at thresh0");
    send(16'h020A, 2'd0, 1'b1, "R3 thresh0 count2 near");
    idle(1);
  endtask

  task automatic t_idle();  // R9
    thresh = 3'd2;
    for (int i = 0; i < 3; i++) send(16'h000C, 2'd1, i == 2, "R9 train");
    idle(4);
    send(16'h000C, 2'd1, 1'b1, "R9 state kept across idle");
    idle(1);
  endtask

  task automatic t_reset();  // R8
    do_reset();
    thresh = 3'd2;
    send(16'h000C, 2'd1, 1'b0, "R8 after reset far");
    send(16'h0003, 2'd2, 1'b0, "R8 after reset far b");
    idle(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    chk(dec_valid == 1'b0 && dec_near == 1'b0, "R8 initial reset", int'(dec_valid), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    t_run();
    t_owner();
    t_alias();
    t_sat();
    t_idle();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule